// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Interrupt

This peripheral keeps time as a 32-bit count of whole seconds. An internal divider turns the input clock into a one-second tick, and the count advances on each tick while the counter is enabled. Software talks to the block through a simple 32-bit register bus. The bus has a byte address, a read strobe, a write strobe, write data and registered read data.

Software can set the time by writing a new value into a staging register. The value is not applied at once: it takes effect at the next one-second tick. Software can also program a match value. When a tick brings the count to that value, a raw status flag latches. Two control bits, an enable and a mask, gate the raw flag into a masked status and the interrupt output. Reading a dedicated acknowledge register clears the flag. A read-only identification register returns a constant fixed at build time.

Top module: `sec_rtc`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 except identification, and `irq` is low.
- R2: While the counter enable (control bit 2) is 1, the count advances once every PRESCALE clocks. The first advance comes PRESCALE clocks after the edge that sets the enable. While the enable is 0, the count holds and the divider is held at zero, so partial progress is discarded.
- R3: A write to the staging register (offset 0x08) leaves the count unchanged. At the next tick the count takes the staged value.
- R4: At 0xFFFFFFFF a tick moves the count to 0 when wrap select (control bit 3) is 1. When wrap select is 0, the tick moves the count to the staging register value instead.
- R5: When a tick makes the count equal the match register (offset 0x04), raw status (offset 0x14, bit 0) sets on that edge. This happens whatever the interrupt enable and mask are.
- R6: Masked status (offset 0x10, bit 0) and `irq` equal raw status AND interrupt enable (control bit 0) AND NOT interrupt mask (control bit 1).
- R7: A read of the acknowledge register (offset 0x18) returns the raw status bit and then clears it. A write to 0x18 has no effect on status or `irq`.
- R8: The count (0x00), match, staging and control (0x0C, bits 3:0) registers all read back. Writes to count, status, identification (0x1C) and unmapped offsets are ignored. Unmapped offsets read 0, and identification returns VERSION. Read data appears on `rdata` the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the prescaler source |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Byte address of the register access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Match interrupt, level |

## Verification
The bench builds the block with PRESCALE = 4, so one "second" lasts four clocks. This lets several ticks, full wrap sequences and match events happen in a few dozen cycles. The bench starts from a count of 0xFFFFFFFE or 0xFFFFFFFF by staging it through the load register, which brings both wrap modes within reach. ADDR_W = 6 gives an address space of 64 bytes, so offsets above the register map exist and can be checked as unmapped. A distinctive VERSION constant makes the identification read unambiguous.

// File: rtl/rtc_pkg.sv
// Package: shared register offsets and control-field layout for the seconds RTC.
// Assumes byte addressing with word-aligned 32-bit registers.
package rtc_pkg;

    localparam int OFF_COUNT = 'h00;
    localparam int OFF_MATCH = 'h04;
    localparam int OFF_LOAD  = 'h08;
    localparam int OFF_CTRL  = 'h0C;
    localparam int OFF_MSTAT = 'h10;
    localparam int OFF_RSTAT = 'h14;
    localparam int OFF_ACK   = 'h18;
    localparam int OFF_IDENT = 'h1C;

    localparam int CTRL_W = 4;

    // Control field, bit 3 down to bit 0.
    typedef struct packed {
        logic wrap_zero;   // bit 3: roll over to zero instead of the staged value
        logic run;         // bit 2: counter enable
        logic irq_mask;    // bit 1: interrupt mask
        logic irq_on;      // bit 0: interrupt enable
    } rtc_ctrl_t;

endpackage

// File: rtl/rtc_prescaler.sv
// Module: rtc_prescaler
// Divides the input clock down to a single-cycle one-second tick.
// Assumes PRESCALE >= 1. With en low the divider is held at zero.
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE <= 1) begin : g_bypass
            // Purpose: every enabled cycle is a tick when no division is asked for.
            logic unused_div;
            assign unused_div = clk ^ rst_n;
            assign tick = en;
        end else begin : g_div
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] div_q;

            // Purpose: count input clocks, restart at the end of each second.
            always_ff @(posedge clk) begin
                if (!rst_n)              div_q <= '0;
                else if (!en)            div_q <= '0;
                else if (div_q == LAST)  div_q <= '0;
                else                     div_q <= div_q + 1'b1;
            end

            assign tick = en && (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/rtc_counter.sv
// Module: rtc_counter
// Holds the seconds count, the staged-load flag and the raw match status.
// Assumes tick is a single-cycle pulse; load_wr marks a new staged value.
module rtc_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wrap_zero,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] match_val,
    input  logic              ack_clr,
    output logic [DATA_W-1:0] count,
    output logic              raw
);

    localparam logic [DATA_W-1:0] TOP = '1;

    logic              pend_q;
    logic [DATA_W-1:0] nxt;

    // Purpose: pick the value the count takes at the coming tick.
    always_comb begin
        if (pend_q)            nxt = load_val;
        else if (count == TOP) nxt = wrap_zero ? '0 : load_val;
        else                   nxt = count + 1'b1;
    end

    // Purpose: advance the count on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (tick)  count <= nxt;
    end

    // Purpose: remember that a staged value waits for the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (load_wr)  pend_q <= 1'b1;
        else if (tick)     pend_q <= 1'b0;
    end

    // Purpose: latch a match on the tick; acknowledge clears unless a new match lands.
    always_ff @(posedge clk) begin
        if (!rst_n)                         raw <= 1'b0;
        else if (tick && nxt == match_val)  raw <= 1'b1;
        else if (ack_clr)                   raw <= 1'b0;
    end

endmodule

// File: rtl/rtc_regs.sv
// Module: rtc_regs
// Register file and read mux of the seconds RTC.
// Assumes single-cycle strobes; rd_en and wr_en are not asserted together.
module rtc_regs
    import rtc_pkg::*;
#(
    parameter int          ADDR_W  = 6,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] VERSION = 32'h0001_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count,
    input  logic              raw,
    input  logic              masked,
    output rtc_ctrl_t         ctrl,
    output logic [DATA_W-1:0] match_val,
    output logic [DATA_W-1:0] load_val,
    output logic              load_wr,
    output logic              ack_clr,
    output logic [DATA_W-1:0] rdata
);

    logic              sel_match, sel_load, sel_ctrl;
    logic [DATA_W-1:0] rd_mux;

    assign sel_match = (addr == ADDR_W'(OFF_MATCH));
    assign sel_load  = (addr == ADDR_W'(OFF_LOAD));
    assign sel_ctrl  = (addr == ADDR_W'(OFF_CTRL));
    assign load_wr   = wr_en && sel_load;
    assign ack_clr   = rd_en && (addr == ADDR_W'(OFF_ACK));

    // Purpose: writable registers; everything else ignores writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            match_val <= '0;
            load_val  <= '0;
        end else if (wr_en) begin
            if (sel_ctrl)  ctrl      <= rtc_ctrl_t'(wdata[CTRL_W-1:0]);
            if (sel_match) match_val <= wdata;
            if (sel_load)  load_val  <= wdata;
        end
    end

    // Purpose: select the read value for the addressed register.
    always_comb begin
        rd_mux = '0;
        case (addr)
            ADDR_W'(OFF_COUNT): rd_mux = count;
            ADDR_W'(OFF_MATCH): rd_mux = match_val;
            ADDR_W'(OFF_LOAD):  rd_mux = load_val;
            ADDR_W'(OFF_CTRL):  rd_mux = DATA_W'(ctrl);
            ADDR_W'(OFF_MSTAT): rd_mux = DATA_W'(masked);
            ADDR_W'(OFF_RSTAT): rd_mux = DATA_W'(raw);
            ADDR_W'(OFF_ACK):   rd_mux = DATA_W'(raw);
            ADDR_W'(OFF_IDENT): rd_mux = DATA_W'(VERSION);
            default:            rd_mux = '0;
        endcase
    end

    // Purpose: register read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_en)  rdata <= rd_mux;
    end

endmodule

// File: rtl/sec_rtc.sv
// Module: sec_rtc (top)
// Seconds counter RTC: prescaler, count with staged load, match status, interrupt.
// Assumes a single bus master issuing one-cycle strobes; ADDR_W >= 5, DATA_W = 32.
module sec_rtc
    import rtc_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter int          DATA_W   = 32,
    parameter int          PRESCALE = 32768,
    parameter logic [31:0] VERSION  = 32'h0001_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    rtc_ctrl_t         ctrl;
    logic              tick, raw, masked, load_wr, ack_clr;
    logic              run, irq_on, irq_mask;
    logic [DATA_W-1:0] count, match_val, load_val;

    assign run      = ctrl.run;
    assign irq_on   = ctrl.irq_on;
    assign irq_mask = ctrl.irq_mask;
    assign masked   = raw && irq_on && !irq_mask;
    assign irq      = masked;

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (run),
        .tick (tick)
    );

    rtc_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wrap_zero(ctrl.wrap_zero),
        .load_wr  (load_wr),
        .load_val (load_val),
        .match_val(match_val),
        .ack_clr  (ack_clr),
        .count    (count),
        .raw      (raw)
    );

    rtc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .count    (count),
        .raw      (raw),
        .masked   (masked),
        .ctrl     (ctrl),
        .match_val(match_val),
        .load_val (load_val),
        .load_wr  (load_wr),
        .ack_clr  (ack_clr),
        .rdata    (rdata)
    );

endmodule

// File: rtl/rtc_checker.sv
// Module: rtc_checker
// Temporal properties of the seconds RTC, attached to the top by bind.
// Assumes the signal names of sec_rtc.
module rtc_checker
    import rtc_pkg::*;
#(
    parameter int          ADDR_W  = 6,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] VERSION = 32'h0001_0003
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic              tick,
    input logic              run,
    input logic              irq_on,
    input logic              irq_mask,
    input logic              raw,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] match_val
);

    AST_NO_TICK_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);                                                          // R2
    AST_COUNT_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));                                                // R2
    AST_RAW_RISES_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> (count == match_val));                                     // R5
    AST_RAW_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !raw) |=> !raw);                                                // R5
    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw);                                                             // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_on && !irq_mask));                                           // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFF_ACK) && !tick) |=> !raw);                   // R7
    AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFF_IDENT)) |=> (rdata == DATA_W'(VERSION)));   // R8

endmodule

bind sec_rtc rtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .irq      (irq),
    .tick     (tick),
    .run      (run),
    .irq_on   (irq_on),
    .irq_mask (irq_mask),
    .raw      (raw),
    .count    (count),
    .match_val(match_val)
);

// File: tb/tb_sec_rtc.sv
// Bench for sec_rtc: vector table for register access, then directed timing tests.
module tb_sec_rtc;

    localparam int          AW    = 6;
    localparam int          DW    = 32;
    localparam int          PS    = 4;
    localparam logic [31:0] TBVER = 32'hA5C3_0102;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    sec_rtc #(.ADDR_W(AW), .DATA_W(DW), .PRESCALE(PS), .VERSION(TBVER)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    // Counter stays stopped throughout the table, so results are timing-free.
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h04, 32'h0000_0005, 32'h0, 8'd8},        // R8 match write
        '{1'b0, 8'h04, 32'h0,         32'h0000_0005, 8'd8},
        '{1'b1, 8'h08, 32'h0000_1234, 32'h0, 8'd3},        // R3 stage a value
        '{1'b0, 8'h08, 32'h0,         32'h0000_1234, 8'd8},
        '{1'b0, 8'h00, 32'h0,         32'h0, 8'd3},        // R3 count untouched
        '{1'b1, 8'h00, 32'h0000_DEAD, 32'h0, 8'd8},
        '{1'b0, 8'h00, 32'h0,         32'h0, 8'd8},        // R8 count not writable
        '{1'b1, 8'h0C, 32'h0000_00FA, 32'h0, 8'd8},
        '{1'b0, 8'h0C, 32'h0,         32'h0000_000A, 8'd8},// R8 only bits 3:0 kept
        '{1'b1, 8'h1C, 32'h0,         32'h0, 8'd8},
        '{1'b0, 8'h1C, 32'h0,         TBVER, 8'd8},        // R8 ident constant
        '{1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0, 8'd8},
        '{1'b0, 8'h24, 32'h0,         32'h0, 8'd8},        // R8 unmapped reads 0
        '{1'b1, 8'h14, 32'h1,         32'h0, 8'd8},
        '{1'b0, 8'h14, 32'h0,         32'h0, 8'd8},        // R8 status not writable
        '{1'b1, 8'h0C, 32'h0,         32'h0, 8'd8}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge.
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        addr = a[AW-1:0]; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        addr = a[AW-1:0]; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values of every mapped word
        for (int i = 0; i < 8; i++) begin
            bus_rd(8'(i * 4), v);
            check($sformatf("R1 reset offset %0h", i * 4), v, (i == 7) ? TBVER : 32'h0);
        end
        check("R1 irq low after reset", {31'b0, irq}, 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_wr(VECS[i].a, VECS[i].d);
            else begin
                bus_rd(VECS[i].a, v);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
            end
        end

        // R3/R2: staged 0x1234 lands at the first tick, PS clocks after enable
        bus_wr(8'h0C, 32'h4); idle(PS); bus_wr(8'h0C, 32'h0);
        bus_rd(8'h00, v); check("R3 staged value applied at tick", v, 32'h1234);
        bus_wr(8'h0C, 32'h4); idle(PS); bus_wr(8'h0C, 32'h0);
        bus_rd(8'h00, v); check("R2 one step per second", v, 32'h1235);
        // R2: partial second is discarded by stopping
        bus_wr(8'h0C, 32'h4); idle(2); bus_wr(8'h0C, 32'h0);
        bus_wr(8'h0C, 32'h4); idle(2); bus_wr(8'h0C, 32'h0);
        bus_rd(8'h00, v); check("R2 divider restarts after stop", v, 32'h1235);

        // R4: rollover to zero with wrap select set
        bus_wr(8'h08, 32'hFFFF_FFFF);
        bus_wr(8'h0C, 32'hC); idle(2 * PS); bus_wr(8'h0C, 32'h0);
        bus_rd(8'h00, v); check("R4 wrap to zero", v, 32'h0);
        // R4: rollover to staged value with wrap select clear
        bus_wr(8'h08, 32'hFFFF_FFFE);
        bus_wr(8'h0C, 32'h4); idle(2 * PS); bus_wr(8'h0C, 32'h0);
        bus_rd(8'h00, v); check("R4 count reaches top", v, 32'hFFFF_FFFF);
        bus_wr(8'h0C, 32'h4); idle(PS); bus_wr(8'h0C, 32'h0);
        bus_rd(8'h00, v); check("R4 wrap to staged value", v, 32'hFFFF_FFFE);

        // R5: match sets raw status with interrupt disabled
        bus_wr(8'h04, 32'd11);
        bus_wr(8'h08, 32'd10);
        bus_wr(8'h0C, 32'h4); idle(2 * PS); bus_wr(8'h0C, 32'h0);
        bus_rd(8'h00, v); check("R5 count at match", v, 32'd11);
        bus_rd(8'h14, v); check("R5 raw set by match", v, 32'h1);
        bus_rd(8'h10, v); check("R6 masked low while disabled", v, 32'h0);
        check("R6 irq low while disabled", {31'b0, irq}, 32'h0);
        // R6: enable and mask gating
        bus_wr(8'h0C, 32'h1);
        check("R6 irq high when enabled", {31'b0, irq}, 32'h1);
        bus_rd(8'h10, v); check("R6 masked status high", v, 32'h1);
        bus_wr(8'h0C, 32'h3);
        check("R6 irq low when masked", {31'b0, irq}, 32'h0);
        bus_rd(8'h14, v); check("R6 raw kept while masked", v, 32'h1);
        bus_wr(8'h0C, 32'h1);
        // R7: acknowledge read returns and clears
        bus_rd(8'h18, v); check("R7 ack read returns raw", v, 32'h1);
        check("R7 irq dropped by ack", {31'b0, irq}, 32'h0);
        bus_rd(8'h14, v); check("R7 raw cleared by ack", v, 32'h0);

        // R7: write to acknowledge has no effect
        bus_wr(8'h04, 32'd12);
        bus_wr(8'h0C, 32'h5); idle(PS); bus_wr(8'h0C, 32'h1);
        check("R5 irq on second match", {31'b0, irq}, 32'h1);
        bus_wr(8'h18, 32'hFFFF_FFFF);
        check("R7 ack write keeps irq", {31'b0, irq}, 32'h1);
        bus_rd(8'h14, v); check("R7 ack write keeps raw", v, 32'h1);
        bus_rd(8'h18, v);
        check("R7 final ack clears irq", {31'b0, irq}, 32'h0);

        finish_run();
    end

endmodule